// File: doc/BRIEF.md
# One-Hot ROM Bank Selector

This block chooses which one of four 2 KB expansion ROM banks, if any, answers CPU reads in the address window $D800–$DFFF. Software picks a bank by writing a control byte to address $D1E3. A four-bit one-hot field inside that byte names the bank. The control register cannot be read back. The block holds the field, produces one chip select per bank, and forms the address presented to the ROM.

When the held field is all zero, no bank drives the window. The host's built-in floating-point ROM then keeps that range. While any bank is selected, a dedicated output tells the host to switch its math ROM off. A write that sets more than one select bit is treated as a request for no bank, so two ROMs never drive the bus together.

All pins are plain control and address signals sampled every cycle. There is no stream traffic, so there is no valid/ready handshake and no back-pressure. A CPU access completes in the cycle it is presented.

Top module: `rom_bank_sel`

## Requirements
- R1: After reset the held select field is zero: every bank chip select is low and `math_rom_off` is low.
- R2: A write (`cpu_wr`=1) to address $D1E3 whose data bits 5..2 contain exactly one 1 selects a bank from the next clock edge on. Bit 2 selects bank 0, bit 3 bank 1, bit 4 bank 2 and bit 5 bank 3. Data bits 7, 6, 1 and 0 have no effect.
- R3: A write to $D1E3 with data bits 5..2 all zero deselects every bank, and `math_rom_off` drops.
- R4: A write to $D1E3 that sets two or more of data bits 5..2 deselects every bank.
- R5: Writes to any address other than $D1E3 leave the selection unchanged.
- R6: `bank_cs[i]` is high only while `cpu_rd`=1, the address lies in $D800–$DFFF inclusive, and bank i is selected. Reads at $D7FF and $E000 assert no chip select.
- R7: A write into $D800–$DFFF asserts no chip select and does not alter the selection.
- R8: `rom_addr` equals {selected bank index (2 bits), CPU address bits 10..0} whenever a chip select is high.
- R9: `math_rom_off` is high exactly while a bank is selected, whether or not a bus access is in progress.
- R10: At most one `bank_cs` bit is high at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_rd | input | 1 | CPU read strobe |
| bank_cs | output | 4 | Per-bank chip select, bit i for bank i |
| rom_addr | output | 13 | ROM address: bank index and offset in the bank |
| math_rom_off | output | 1 | High to disable the host floating-point ROM |

## Verification
The hardest case to reach is a multi-hot write arriving while another bank is already active. It must collapse the selection to nothing, not merge with the old bank or keep it. The bench first selects a bank, then writes patterns with two and with four select bits set. After each write it probes the window with a read, which shows the selection has cleared. Reads exactly one address outside each end of the window, and writes into the window, check that the range compare and the read qualification agree.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  typedef enum logic [1:0] {
    FLD_NONE = 2'd0,
    FLD_ONE  = 2'd1,
    FLD_MANY = 2'd2
  } fld_kind_e;

  function automatic fld_kind_e classify(input int unsigned ones);
    if (ones == 0) return FLD_NONE;
    else if (ones == 1) return FLD_ONE;
    else return FLD_MANY;
  endfunction
endpackage

// File: rtl/rbs_sel_reg.sv
module rbs_sel_reg #(
  parameter int unsigned NB        = 4,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned SEL_LSB   = 2,
  parameter logic [15:0] CTRL_ADDR = 16'hD1E3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [NB-1:0]     sel_q
);
  import rbs_pkg::*;

  localparam logic [DATA_W-1:0] FIELD_MASK = DATA_W'(((1 << NB) - 1) << SEL_LSB);

  logic            wr_hit;
  logic [NB-1:0]   field;
  fld_kind_e       kind;
  logic [NB-1:0]   sel_d;
  logic            unused_wbits;

  assign wr_hit       = wr_en && (addr == ADDR_W'(CTRL_ADDR));
  assign field        = wdata[SEL_LSB +: NB];
  assign kind         = classify($countones(field));
  assign unused_wbits = ^(wdata & ~FIELD_MASK);

  always_comb begin
    sel_d = sel_q;
    if (wr_hit) begin
      unique case (kind)
        FLD_ONE:  sel_d = field;
        default:  sel_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  p_sel_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_q));

  p_one_bit_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && $countones(field) == 1) |=> (sel_q == $past(field)));

  p_zero_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && field == '0) |=> (sel_q == '0));

  p_multi_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && $countones(field) > 1) |=> (sel_q == '0));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(sel_q));
endmodule

// File: rtl/rbs_win_dec.sv
module rbs_win_dec #(
  parameter int unsigned ADDR_W   = 16,
  parameter logic [15:0] WIN_BASE = 16'hD800,
  parameter logic [15:0] WIN_LAST = 16'hDFFF
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  output logic              rd_hit
);
  logic in_win;

  assign in_win = (addr >= ADDR_W'(WIN_BASE)) && (addr <= ADDR_W'(WIN_LAST));
  assign rd_hit = rd_en && in_win;
endmodule

// File: rtl/rbs_bank_drv.sv
module rbs_bank_drv #(
  parameter int unsigned NB      = 4,
  parameter int unsigned BANK_AW = 11,
  localparam int unsigned IDX_W  = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NB-1:0]      sel,
  input  logic               rd_hit,
  input  logic [BANK_AW-1:0] offset,
  output logic [NB-1:0]      bank_cs,
  output logic [IDX_W+BANK_AW-1:0] rom_addr,
  output logic               math_off
);
  logic [IDX_W-1:0] idx;

  always_comb begin
    idx = '0;
    for (int i = 0; i < NB; i++) begin
      if (sel[i]) idx = IDX_W'(i);
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_cs
    assign bank_cs[g] = rd_hit && sel[g];
  end

  assign rom_addr = {idx, offset};
  assign math_off = |sel;

  p_cs_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_cs));

  p_cs_needs_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_cs) |-> rd_hit);

  p_cs_implies_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_cs) |-> math_off);

  p_addr_offset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_cs) |-> (rom_addr[BANK_AW-1:0] == offset));
endmodule

// File: rtl/rom_bank_sel.sv
module rom_bank_sel #(
  parameter int unsigned NB        = 4,
  parameter int unsigned BANK_AW   = 11,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned SEL_LSB   = 2,
  parameter logic [15:0] CTRL_ADDR = 16'hD1E3,
  parameter logic [15:0] WIN_BASE  = 16'hD800,
  parameter logic [15:0] WIN_LAST  = 16'hDFFF,
  localparam int unsigned IDX_W    = (NB > 1) ? $clog2(NB) : 1,
  localparam int unsigned ROM_AW   = IDX_W + BANK_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  output logic [NB-1:0]     bank_cs,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              math_rom_off
);
  logic [NB-1:0] sel_q;
  logic          rd_hit;

  rbs_sel_reg #(
    .NB(NB), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .SEL_LSB(SEL_LSB), .CTRL_ADDR(CTRL_ADDR)
  ) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(cpu_wr),
    .addr(cpu_addr), .wdata(cpu_wdata), .sel_q(sel_q)
  );

  rbs_win_dec #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_LAST(WIN_LAST)
  ) u_win (
    .addr(cpu_addr), .rd_en(cpu_rd), .rd_hit(rd_hit)
  );

  rbs_bank_drv #(
    .NB(NB), .BANK_AW(BANK_AW)
  ) u_drv (
    .clk(clk), .rst_n(rst_n), .sel(sel_q), .rd_hit(rd_hit),
    .offset(cpu_addr[BANK_AW-1:0]),
    .bank_cs(bank_cs), .rom_addr(rom_addr), .math_off(math_rom_off)
  );

  p_write_no_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !cpu_rd) |-> (bank_cs == '0));

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (sel_q == '0));
endmodule

// File: tb/tb_rom_bank_sel.sv
module tb_rom_bank_sel;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_wr = 1'b0;
  logic        cpu_rd = 1'b0;
  logic [3:0]  bank_cs;
  logic [12:0] rom_addr;
  logic        math_rom_off;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [3:0] exp_sel = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rom_bank_sel dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .bank_cs(bank_cs),
    .rom_addr(rom_addr), .math_rom_off(math_rom_off)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] model_next(input logic [3:0] cur, input logic [15:0] a,
                                            input logic [7:0] d);
    logic [3:0] f;
    f = d[5:2];
    if (a != 16'hD1E3) return cur;
    if ($countones(f) > 1) return 4'h0;
    return f;
  endfunction

  function automatic logic [1:0] model_idx(input logic [3:0] s);
    for (int i = 0; i < 4; i++) if (s[i]) return 2'(i);
    return 2'd0;
  endfunction

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
    #1;
    chk("R7 no cs during write", 32'(bank_cs), 32'h0);
    @(negedge clk);
    cpu_wr = 1'b0;
    exp_sel = model_next(exp_sel, a, d);
  endtask

  task automatic probe(input string req, input logic [15:0] a);
    logic in_w;
    logic [3:0] ecs;
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    #1;
    in_w = (a >= 16'hD800) && (a <= 16'hDFFF);
    ecs = in_w ? exp_sel : 4'h0;
    chk({req, " cs"}, 32'(bank_cs), 32'(ecs));
    chk("R10 cs onehot0", 32'($countones(bank_cs) <= 1), 32'h1);
    chk("R9 math_rom_off", 32'(math_rom_off), 32'(|exp_sel));
    if (ecs != 0) chk("R8 rom_addr", 32'(rom_addr), 32'({model_idx(exp_sel), a[10:0]}));
    @(negedge clk);
    cpu_rd = 1'b0;
    #1;
    chk("R9 math_rom_off idle", 32'(math_rom_off), 32'(|exp_sel));
    chk("R6 no cs idle", 32'(bank_cs), 32'h0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    exp_sel = '0;
    probe("R1 reset", 16'hD800);
  endtask

  task automatic t_each_bank();
    for (int b = 0; b < 4; b++) begin
      bus_write(16'hD1E3, 8'(1 << (b + 2)));
      probe("R2 select bank", 16'hD800 + 16'(b * 16'h123));
      probe("R8 offset top", 16'hDFFF);
    end
  endtask

  task automatic t_other_bits();
    bus_write(16'hD1E3, 8'hC3 | 8'h08);
    probe("R2 extra bits ignored", 16'hDABC);
    chk("R2 bank1 cs", 32'(exp_sel), 32'h2);
  endtask

  task automatic t_zero();
    bus_write(16'hD1E3, 8'h10);
    bus_write(16'hD1E3, 8'hC3);
    probe("R3 zero field", 16'hD900);
  endtask

  task automatic t_multi();
    bus_write(16'hD1E3, 8'h20);
    probe("R4 before multi", 16'hDC00);
    bus_write(16'hD1E3, 8'h14);
    probe("R4 two bits", 16'hDC00);
    bus_write(16'hD1E3, 8'h08);
    bus_write(16'hD1E3, 8'h3C);
    probe("R4 four bits", 16'hD800);
  endtask

  task automatic t_other_addr();
    bus_write(16'hD1E3, 8'h04);
    bus_write(16'hD1E2, 8'h20);
    bus_write(16'hD1E4, 8'h00);
    bus_write(16'hF1E3, 8'h10);
    probe("R5 other addr", 16'hD812);
  endtask

  task automatic t_bounds();
    bus_write(16'hD1E3, 8'h10);
    probe("R6 below window", 16'hD7FF);
    probe("R6 base", 16'hD800);
    probe("R6 last", 16'hDFFF);
    probe("R6 above window", 16'hE000);
  endtask

  task automatic t_window_write();
    bus_write(16'hDA00, 8'h3C);
    bus_write(16'hD800, 8'h04);
    probe("R7 state kept", 16'hDA00);
  endtask

  initial begin
    t_reset();
    t_each_bank();
    t_other_bits();
    t_zero();
    t_multi();
    t_other_addr();
    t_bounds();
    t_window_write();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule